// File: doc/BRIEF.md
# Descriptor Chain Return Controller

The block follows a linked list of host-mode descriptors: one packet descriptor, then zero or more buffer descriptors linked behind it. It is handed the address of the first descriptor. It reads the fields it needs from a descriptor memory through a synchronous read port. For each descriptor it gives the buffer address and valid length to a data mover. It then decides when each descriptor pointer goes back to a return queue, and whether it goes to the head or the tail of that queue. The mover does the data movement. The queue manager takes the return pushes. Neither is part of this block.

The return behaviour is read from the second header word of the first descriptor. One bit chooses between one return for the whole packet and one return per descriptor. A second bit makes the return early: it happens as soon as the buffer is handed to the mover, not when the mover reports completion. A third bit chooses a head or tail push. That setting applies to every descriptor of the chain. The header words of the buffer descriptors that follow are not used.

The controller is a single state machine. Its states are:
- IDLE: waiting for a start command.
- LAUNCH: starts a descriptor fetch.
- FETCH: waits for the fetch to finish.
- CHECK: validates the first descriptor and latches the return setting.
- ISSUE: offers the buffer to the mover.
- EPUSH: performs an early return push.
- WAIT: waits for the mover's done.
- LPUSH: performs a late return push.
- NEXT: follows the link.
- FAIL: signals an error.

Its transitions are:
- IDLE to LAUNCH when a start with an even address is accepted. A start with an odd address is consumed and the block stays in IDLE.
- LAUNCH to FETCH.
- FETCH to CHECK when the fetch is done.
- CHECK to FAIL when the first descriptor is not host type or its queue id is reserved. Otherwise CHECK to ISSUE.
- ISSUE to EPUSH or to WAIT when the mover accepts.
- EPUSH to WAIT when the queue accepts.
- WAIT to LPUSH or to NEXT once done has been seen.
- LPUSH to NEXT when the queue accepts.
- NEXT to IDLE when the link is zero. Otherwise NEXT to LAUNCH.
- FAIL to IDLE.

Top module: `chain_return_ctrl`

## Requirements
- R1: `start_ready` is high only in IDLE. A start whose address has bit 0 set is a teardown marker: it is consumed, and it causes no read, no mover request, no return push and no error.
- R2: The read port has one cycle of latency. For the first descriptor the block reads the byte offsets 0, 8, 16, 24 and 32, in that order. For each later descriptor it reads the offsets 16, 24 and 32. Consecutive reads within a descriptor step by 8 bytes.
- R3: If bits 31:30 of header word 0 of the first descriptor are not 1 (host), `err` pulses for one cycle and the block returns to IDLE with no mover request and no push.
- R4: A queue id of 0xFFFF in bits 15:0 of header word 2 is reserved. It is handled exactly as in R3, and `ret_qid` never shows 0xFFFF.
- R5: For each descriptor in chain order, `xfer_addr` is the word at offset 24 and `xfer_len` is bits 27:0 of the word at offset 32. The request is held until `xfer_ready` accepts it.
- R6: When word 2 bit 18 is 0 and bit 17 is 0, there is exactly one push. It carries the first descriptor's address and comes after the done of the last buffer.
- R7: When word 2 bit 18 is 0 and bit 17 is 1, there is exactly one push. It carries the first descriptor's address and comes after the first buffer is accepted and before the second is offered.
- R8: When word 2 bit 18 is 1 and bit 17 is 0, every descriptor address is pushed in chain order, each after that descriptor's done.
- R9: When word 2 bit 18 is 1 and bit 17 is 1, every descriptor address is pushed in chain order, each right after its buffer is accepted.
- R10: `ret_head` is word 2 bit 16 and `ret_qid` is word 2 bits 15:0, both from the first descriptor, on every push of the chain. The header words of buffer descriptors are ignored.
- R11: While `ret_valid` is high and `ret_ready` is low, `ret_valid`, `ret_addr`, `ret_qid` and `ret_head` hold.
- R12: A done that arrives while an early push is stalled is remembered, and the walk continues.
- R13: A zero link word (offset 16) ends the chain. The block then returns to IDLE and accepts the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start command valid |
| start_ready | output | 1 | Controller idle, start accepted |
| start_addr | input | ADDR_W | Byte address of first descriptor |
| rd_req | output | 1 | Descriptor memory read request |
| rd_addr | output | ADDR_W | Byte address of the word read |
| rd_data | input | WORD_W | Read data, one cycle after `rd_req` |
| xfer_valid | output | 1 | Buffer request to the mover |
| xfer_ready | input | 1 | Mover accepts the request |
| xfer_addr | output | ADDR_W | Buffer address |
| xfer_len | output | LEN_W | Buffer valid length |
| xfer_done | input | 1 | One-cycle pulse: mover finished the buffer |
| ret_valid | output | 1 | Return push valid |
| ret_ready | input | 1 | Return queue accepts the push |
| ret_addr | output | ADDR_W | Descriptor address returned |
| ret_qid | output | QID_W | Return queue id |
| ret_head | output | 1 | 1: push to head, 0: push to tail |
| err | output | 1 | One-cycle pulse: chain rejected |

## Verification
The two functions that can fall in the same cycle are the mover's completion and a stalled early return. In per-descriptor early mode, the bench holds `ret_ready` low for several cycles after each early push is offered, and gives the mover a one-cycle completion delay. The done pulse therefore arrives while EPUSH is still waiting. It is judged correct when every descriptor is still offered to the mover and pushed in order, and the walk reaches IDLE within a bounded time. A done that was lost would leave the block stuck in WAIT.

// File: rtl/chain_ret_pkg.sv
package chain_ret_pkg;

    localparam int QID_W         = 16;
    localparam int KIND_HI       = 31;
    localparam int KIND_LO       = 30;
    localparam logic [1:0] KIND_HOST = 2'd1;
    localparam int POL_BUF_BIT   = 18;
    localparam int POL_EARLY_BIT = 17;
    localparam int POL_HEAD_BIT  = 16;

    // fetch step numbering: header 0, header 2, link, buffer, length
    localparam int STEP_HDR0 = 0;
    localparam int STEP_HDR2 = 1;
    localparam int STEP_LINK = 2;
    localparam int STEP_BUF  = 3;
    localparam int STEP_LEN  = 4;
    localparam int NUM_STEPS = 5;
    localparam int STEP_BYTES = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_FETCH,
        ST_CHECK,
        ST_ISSUE,
        ST_EPUSH,
        ST_WAIT,
        ST_LPUSH,
        ST_NEXT,
        ST_FAIL
    } walk_state_t;

    typedef struct packed {
        logic             per_buf;
        logic             early;
        logic             to_head;
        logic [QID_W-1:0] qid;
    } ret_pol_t;

    function automatic ret_pol_t decode_pol(input logic [31:0] w2);
        ret_pol_t p;
        p.per_buf = w2[POL_BUF_BIT];
        p.early   = w2[POL_EARLY_BIT];
        p.to_head = w2[POL_HEAD_BIT];
        p.qid     = w2[QID_W-1:0];
        return p;
    endfunction

endpackage

// File: rtl/chain_fetch.sv
module chain_fetch
    import chain_ret_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              first,
    input  logic [ADDR_W-1:0] base,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              done,
    output logic [WORD_W-1:0] fld_w0,
    output logic [WORD_W-1:0] fld_w2,
    output logic [WORD_W-1:0] fld_link,
    output logic [WORD_W-1:0] fld_buf,
    output logic [WORD_W-1:0] fld_len
);

    localparam int STEP_W = $clog2(NUM_STEPS + 1);
    localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(NUM_STEPS - 1);
    localparam logic [STEP_W-1:0] LATER_STEP = STEP_W'(STEP_LINK);

    logic              active;
    logic [STEP_W-1:0] step;
    logic [ADDR_W-1:0] base_q;
    logic              cap_v;
    logic [STEP_W-1:0] cap_step;
    logic              done_q;
    logic [WORD_W-1:0] fld_q [NUM_STEPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active   <= 1'b0;
            step     <= '0;
            base_q   <= '0;
            cap_v    <= 1'b0;
            cap_step <= '0;
            done_q   <= 1'b0;
        end else begin
            cap_v    <= active;
            cap_step <= step;
            done_q   <= cap_v && (cap_step == LAST_STEP);
            if (go) begin
                active <= 1'b1;
                step   <= first ? '0 : LATER_STEP;
                base_q <= base;
            end else if (active) begin
                step <= step + 1'b1;
                if (step == LAST_STEP) begin
                    active <= 1'b0;
                end
            end
        end
    end

    for (genvar gi = 0; gi < NUM_STEPS; gi++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fld_q[gi] <= '0;
            end else if (cap_v && (cap_step == STEP_W'(gi))) begin
                fld_q[gi] <= rd_data;
            end
        end
    end

    assign rd_req   = active;
    assign rd_addr  = base_q + (ADDR_W'(step) * ADDR_W'(STEP_BYTES));
    assign done     = done_q;
    assign fld_w0   = fld_q[STEP_HDR0];
    assign fld_w2   = fld_q[STEP_HDR2];
    assign fld_link = fld_q[STEP_LINK];
    assign fld_buf  = fld_q[STEP_BUF];
    assign fld_len  = fld_q[STEP_LEN];

endmodule

// File: rtl/chain_xfer.sv
module chain_xfer #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_en,
    input  logic [ADDR_W-1:0] buf_in,
    input  logic [LEN_W-1:0]  len_in,
    output logic              xfer_valid,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_ready,
    input  logic              xfer_done,
    output logic              accepted,
    output logic              done_seen
);

    logic done_q;

    assign xfer_valid = issue_en;
    assign xfer_addr  = buf_in;
    assign xfer_len   = len_in;
    assign accepted   = issue_en && xfer_ready;
    assign done_seen  = done_q;

    // completion is remembered from acceptance until the walk consumes it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (accepted) begin
            done_q <= 1'b0;
        end else if (xfer_done) begin
            done_q <= 1'b1;
        end
    end

endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
    import chain_ret_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              start_ready,
    output logic              fetch_go,
    output logic              fetch_first,
    output logic [ADDR_W-1:0] fetch_base,
    input  logic              fetch_done,
    input  logic [WORD_W-1:0] f_w0,
    input  logic [WORD_W-1:0] f_w2,
    input  logic [WORD_W-1:0] f_link,
    input  logic [WORD_W-1:0] f_buf,
    input  logic [WORD_W-1:0] f_len,
    output logic              issue_en,
    output logic [ADDR_W-1:0] issue_buf,
    output logic [LEN_W-1:0]  issue_len,
    input  logic              accepted,
    input  logic              done_seen,
    output logic              ret_valid,
    input  logic              ret_ready,
    output logic [ADDR_W-1:0] ret_addr,
    output logic [QID_W-1:0]  ret_qid,
    output logic              ret_head,
    output logic              err
);

    walk_state_t state_q, state_d;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] head_q;
    logic              first_q;
    ret_pol_t          pol_q;

    logic [ADDR_W-1:0] link_addr;
    logic              link_end;
    logic              bad_first;
    logic              early_push;
    logic              late_push;
    logic              start_take;

    assign link_addr  = f_link[ADDR_W-1:0];
    assign link_end   = (link_addr == '0);
    assign bad_first  = (f_w0[KIND_HI:KIND_LO] != KIND_HOST) ||
                        (f_w2[QID_W-1:0] == '1);
    assign early_push = pol_q.early && (pol_q.per_buf || first_q);
    assign late_push  = !pol_q.early && (pol_q.per_buf || link_end);
    assign start_take = (state_q == ST_IDLE) && start_valid && !start_addr[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_take) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_FETCH;
            ST_FETCH:  if (fetch_done) state_d = ST_CHECK;
            ST_CHECK:  state_d = (first_q && bad_first) ? ST_FAIL : ST_ISSUE;
            ST_ISSUE:  if (accepted) state_d = early_push ? ST_EPUSH : ST_WAIT;
            ST_EPUSH:  if (ret_ready) state_d = ST_WAIT;
            ST_WAIT:   if (done_seen) state_d = late_push ? ST_LPUSH : ST_NEXT;
            ST_LPUSH:  if (ret_ready) state_d = ST_NEXT;
            ST_NEXT:   state_d = link_end ? ST_IDLE : ST_LAUNCH;
            ST_FAIL:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            head_q  <= '0;
            first_q <= 1'b0;
            pol_q   <= '0;
        end else begin
            if (start_take) begin
                cur_q   <= start_addr;
                head_q  <= start_addr;
                first_q <= 1'b1;
            end
            if ((state_q == ST_CHECK) && first_q) begin
                pol_q <= decode_pol(f_w2);
            end
            if ((state_q == ST_NEXT) && !link_end) begin
                cur_q   <= link_addr;
                first_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        start_ready = (state_q == ST_IDLE);
        fetch_go    = (state_q == ST_LAUNCH);
        fetch_first = first_q;
        fetch_base  = cur_q;
        issue_en    = (state_q == ST_ISSUE);
        issue_buf   = f_buf[ADDR_W-1:0];
        issue_len   = f_len[LEN_W-1:0];
        ret_valid   = (state_q == ST_EPUSH) || (state_q == ST_LPUSH);
        ret_addr    = pol_q.per_buf ? cur_q : head_q;
        ret_qid     = pol_q.qid;
        ret_head    = pol_q.to_head;
        err         = (state_q == ST_FAIL);
    end

endmodule

// File: rtl/chain_return_ctrl.sv
module chain_return_ctrl
    import chain_ret_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_done,
    output logic              ret_valid,
    input  logic              ret_ready,
    output logic [ADDR_W-1:0] ret_addr,
    output logic [QID_W-1:0]  ret_qid,
    output logic              ret_head,
    output logic              err
);

    logic              fetch_go;
    logic              fetch_first;
    logic [ADDR_W-1:0] fetch_base;
    logic              fetch_done;
    logic [WORD_W-1:0] f_w0, f_w2, f_link, f_buf, f_len;
    logic              issue_en;
    logic [ADDR_W-1:0] issue_buf;
    logic [LEN_W-1:0]  issue_len;
    logic              accepted;
    logic              done_seen;

    chain_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (fetch_go),
        .first    (fetch_first),
        .base     (fetch_base),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .done     (fetch_done),
        .fld_w0   (f_w0),
        .fld_w2   (f_w2),
        .fld_link (f_link),
        .fld_buf  (f_buf),
        .fld_len  (f_len)
    );

    chain_xfer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_en   (issue_en),
        .buf_in     (issue_buf),
        .len_in     (issue_len),
        .xfer_valid (xfer_valid),
        .xfer_addr  (xfer_addr),
        .xfer_len   (xfer_len),
        .xfer_ready (xfer_ready),
        .xfer_done  (xfer_done),
        .accepted   (accepted),
        .done_seen  (done_seen)
    );

    chain_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_valid (start_valid),
        .start_addr  (start_addr),
        .start_ready (start_ready),
        .fetch_go    (fetch_go),
        .fetch_first (fetch_first),
        .fetch_base  (fetch_base),
        .fetch_done  (fetch_done),
        .f_w0        (f_w0),
        .f_w2        (f_w2),
        .f_link      (f_link),
        .f_buf       (f_buf),
        .f_len       (f_len),
        .issue_en    (issue_en),
        .issue_buf   (issue_buf),
        .issue_len   (issue_len),
        .accepted    (accepted),
        .done_seen   (done_seen),
        .ret_valid   (ret_valid),
        .ret_ready   (ret_ready),
        .ret_addr    (ret_addr),
        .ret_qid     (ret_qid),
        .ret_head    (ret_head),
        .err         (err)
    );

endmodule

// File: rtl/chain_return_ctrl_chk.sv
module chain_return_ctrl_chk
    import chain_ret_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_ready,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              xfer_valid,
    input logic              xfer_ready,
    input logic [ADDR_W-1:0] xfer_addr,
    input logic [LEN_W-1:0]  xfer_len,
    input logic              ret_valid,
    input logic              ret_ready,
    input logic [ADDR_W-1:0] ret_addr,
    input logic [QID_W-1:0]  ret_qid,
    input logic              ret_head,
    input logic              err
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready |-> (!rd_req && !xfer_valid && !ret_valid));

    // R2
    rd_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && $past(rd_req)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(STEP_BYTES)));

    // R3
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!err && start_ready));

    // R4
    qid_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> (ret_qid != '1));

    // R5
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_len)));

    // R11
    ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_ready) |=>
        (ret_valid && $stable(ret_addr) && $stable(ret_qid) && $stable(ret_head)));

    // R9
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ret_valid, xfer_valid, err}));

endmodule

bind chain_return_ctrl chain_return_ctrl_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_ready (start_ready),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .xfer_valid  (xfer_valid),
    .xfer_ready  (xfer_ready),
    .xfer_addr   (xfer_addr),
    .xfer_len    (xfer_len),
    .ret_valid   (ret_valid),
    .ret_ready   (ret_ready),
    .ret_addr    (ret_addr),
    .ret_qid     (ret_qid),
    .ret_head    (ret_head),
    .err         (err)
);

// File: tb/chain_return_ctrl_bench.sv
module chain_return_ctrl_bench;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int LEN_W  = 28;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_valid = 1'b0;
    logic              start_ready;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data = '0;
    logic              xfer_valid;
    logic              xfer_ready = 1'b1;
    logic [ADDR_W-1:0] xfer_addr;
    logic [LEN_W-1:0]  xfer_len;
    logic              xfer_done = 1'b0;
    logic              ret_valid;
    logic              ret_ready = 1'b1;
    logic [ADDR_W-1:0] ret_addr;
    logic [15:0]       ret_qid;
    logic              ret_head;
    logic              err;

    always #5 clk = ~clk;

    chain_return_ctrl u_chain_return_ctrl (.*);

    typedef struct {
        logic [31:0] addr;
        logic [15:0] qid;
        logic        head;
        int          by_done;
        int          cnt;
        string       req;
    } ret_item_t;

    typedef struct {
        logic [31:0] addr;
        logic [27:0] len;
    } xfer_item_t;

    ret_item_t  ret_q[$];
    xfer_item_t xq[$];
    logic [31:0] mem [int];

    int total = 0, bad = 0, cyc = 0;
    int rd_cnt = 0, acc_cnt = 0, done_cnt = 0, err_cnt = 0;
    int done_timer = 0, done_dly = 3, hold_cfg = 0, hold_left = 0;
    bit throttle = 0, prev_stall = 0;
    logic [31:0] prev_addr = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // descriptor memory model, one cycle read latency
    always @(posedge clk) begin
        if (rd_req) rd_data <= mem.exists(int'(rd_addr >> 2)) ? mem[int'(rd_addr >> 2)] : 32'h0;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // environment driver, away from the edge
    initial begin
        forever begin
            @(posedge clk); #2;
            if (done_timer > 0) begin
                done_timer--;
                xfer_done = (done_timer == 0);
            end else begin
                xfer_done = 1'b0;
            end
            xfer_ready = throttle ? cyc[1] : 1'b1;
            if (ret_valid && hold_left > 0) begin
                ret_ready = 1'b0;
                hold_left--;
            end else begin
                ret_ready = 1'b1;
            end
        end
    end

    // monitor and scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_stall)
                    chk(ret_valid && ret_addr == prev_addr, "R11", "held push",
                        {31'h0, ret_valid, ret_addr}, {32'h1, prev_addr});
                prev_stall = ret_valid && !ret_ready;
                prev_addr  = ret_addr;
                if (ret_valid && ret_ready) begin
                    if (ret_q.size() == 0) begin
                        chk(0, "R6", "unexpected push", ret_addr, 0);
                    end else begin
                        ret_item_t e;
                        e = ret_q.pop_front();
                        chk(ret_addr == e.addr, e.req, "ret_addr", ret_addr, e.addr);
                        chk(ret_qid == e.qid && ret_head == e.head, "R10", "qid/head",
                            {ret_head, ret_qid}, {e.head, e.qid});
                        if (e.by_done != 0)
                            chk(done_cnt == e.cnt, e.req, "dones before push", done_cnt, e.cnt);
                        else
                            chk(acc_cnt == e.cnt, e.req, "accepts before push", acc_cnt, e.cnt);
                    end
                    hold_left = hold_cfg;
                end
                if (xfer_valid && xfer_ready) begin
                    if (xq.size() == 0) begin
                        chk(0, "R5", "unexpected xfer", xfer_addr, 0);
                    end else begin
                        xfer_item_t x;
                        x = xq.pop_front();
                        chk(xfer_addr == x.addr && xfer_len == x.len, "R5", "xfer",
                            {xfer_addr, 4'h0, xfer_len}, {x.addr, 4'h0, x.len});
                    end
                    acc_cnt++;
                    done_timer = done_dly;
                end
                if (xfer_done) done_cnt++;
                if (rd_req) rd_cnt++;
                if (err) err_cnt++;
            end
        end
    end

    // build a chain and predict the mover requests and return pushes
    task automatic make_chain(input logic [31:0] base, input int n, input logic [1:0] typ,
                              input bit rp, input bit er, input bit hd, input logic [15:0] qid,
                              input bit expect_ok, input string req);
        for (int i = 0; i < n; i++) begin
            logic [31:0] a;
            a = base + 32'(i * 64);
            mem[int'(a >> 2)]       = (i == 0) ? {typ, 8'h00, 22'd500} : 32'hC000_0000;
            mem[int'((a + 8) >> 2)] = (i == 0) ? {13'h0, rp, er, hd, qid} : 32'h0007_FFFF;
            mem[int'((a + 16) >> 2)] = (i == n - 1) ? 32'h0 : base + 32'((i + 1) * 64);
            mem[int'((a + 24) >> 2)] = 32'h8000_0000 + base + 32'(i * 256);
            mem[int'((a + 32) >> 2)] = {4'hA, 28'(64 + i * 16)};
            if (expect_ok) begin
                xfer_item_t x;
                x.addr = 32'h8000_0000 + base + 32'(i * 256);
                x.len  = 28'(64 + i * 16);
                xq.push_back(x);
                if (rp) begin
                    ret_item_t e;
                    e.addr = a; e.qid = qid; e.head = hd;
                    e.by_done = er ? 0 : 1; e.cnt = i + 1; e.req = req;
                    ret_q.push_back(e);
                end
            end
        end
        if (expect_ok && !rp) begin
            ret_item_t e;
            e.addr = base; e.qid = qid; e.head = hd;
            e.by_done = er ? 0 : 1; e.cnt = er ? 1 : n; e.req = req;
            ret_q.push_back(e);
        end
    endtask

    task automatic run_pkt(input logic [31:0] addr, input int exp_rd, input int exp_err,
                           input string req);
        int t;
        rd_cnt = 0; acc_cnt = 0; done_cnt = 0; err_cnt = 0; hold_left = hold_cfg;
        @(posedge clk); #2;
        start_valid = 1'b1;
        start_addr  = addr;
        @(negedge clk);
        while (!start_ready) @(negedge clk);
        @(posedge clk); #2;
        start_valid = 1'b0;
        t = 0;
        @(negedge clk);
        while (!start_ready && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        chk(t < 3000, "R13", "walk returns to idle", t, 0);
        chk(rd_cnt == exp_rd, "R2", "read count", rd_cnt, exp_rd);
        chk(err_cnt == exp_err, exp_err != 0 ? req : "R3", "error pulses", err_cnt, exp_err);
        chk(ret_q.size() == 0, req, "pushes left over", ret_q.size(), 0);
        chk(xq.size() == 0, "R5", "mover requests left over", xq.size(), 0);
        ret_q.delete();
        xq.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(start_ready && !ret_valid && !xfer_valid && !err && !rd_req, "R1", "reset state",
            {start_ready, ret_valid, xfer_valid, err, rd_req}, 5'b10000);

        // R6 per-packet, late, tail push, three descriptors
        make_chain(32'h0000_1000, 3, 2'd1, 0, 0, 0, 16'h0012, 1, "R6");
        run_pkt(32'h0000_1000, 5 + 3 * 2, 0, "R6");

        // R7 per-packet, early, head push
        done_dly = 6;
        make_chain(32'h0000_2000, 2, 2'd1, 0, 1, 1, 16'h0345, 1, "R7");
        run_pkt(32'h0000_2000, 5 + 3, 0, "R7");

        // R8 per-buffer, late, mover throttled
        done_dly = 3; throttle = 1;
        make_chain(32'h0000_3000, 3, 2'd1, 1, 0, 1, 16'h0777, 1, "R8");
        run_pkt(32'h0000_3000, 5 + 3 * 2, 0, "R8");
        throttle = 0;

        // R9 and R12 per-buffer early, push stalled while done arrives
        done_dly = 1; hold_cfg = 4;
        make_chain(32'h0000_4000, 4, 2'd1, 1, 1, 0, 16'h0ABC, 1, "R12");
        run_pkt(32'h0000_4000, 5 + 3 * 3, 0, "R12");
        hold_cfg = 0; done_dly = 3;

        // R9 single descriptor, early per-buffer
        make_chain(32'h0000_5000, 1, 2'd1, 1, 1, 1, 16'h0000, 1, "R9");
        run_pkt(32'h0000_5000, 5, 0, "R9");

        // R1 teardown marker start is dropped
        run_pkt(32'h0000_6001, 0, 0, "R1");

        // R3 first descriptor is not host type
        make_chain(32'h0000_7000, 2, 2'd2, 1, 0, 0, 16'h0001, 0, "R3");
        run_pkt(32'h0000_7000, 5, 1, "R3");

        // R4 reserved return queue id
        make_chain(32'h0000_8000, 2, 2'd1, 1, 1, 0, 16'hFFFF, 0, "R4");
        run_pkt(32'h0000_8000, 5, 1, "R4");

        // R13 a following good chain is still accepted
        make_chain(32'h0000_9000, 2, 2'd1, 0, 0, 1, 16'h0042, 1, "R13");
        run_pkt(32'h0000_9000, 5 + 3, 0, "R13");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule